// File: doc/BRIEF.md
# Translation Table Register Front End

This block is the register port through which privileged software programs and inspects a small translation table, and the place where the MMU's process-identifier, zone-protection and index registers live. Each table entry holds a 32-bit tag word, a 64-bit data word and an 8-bit owner tag. Software reaches the entry picked by the index register through two window registers: one for the tag word and one for the data word. The data word window also takes an extended flag that selects its upper 32 bits.

A write to the search register starts an associative lookup in an external engine. The block presents the page-aligned address and the privilege mode, stalls the port for one cycle, and then registers the result into the index register. A hit stores the matching slot. A miss raises a sticky flag in bit 31. Two build-time parameters gate every access: the MMU level and the table access level. They give a block that is fully disabled, a block that is read-mostly, or a block with full access.

The control is a two-state machine:
- `ST_IDLE` accepts requests. On a permitted write to the search register it takes the *launch* transition to `ST_SEARCH`.
- `ST_SEARCH` drives the lookup, raises `busy`, and always takes the *retire* transition back to `ST_IDLE` on the next edge.

Top module: `mmu_tlb_port`

## Requirements
- R1: After reset, the index, PID and zone registers read 0, every table word reads 0, and `busy` and `rsp_valid` are low.
- R2: Register numbers are:
  - 0: data word
  - 1: tag word
  - 2: PID
  - 3: zone protection
  - 4: index
  - 5: search
  - 6 and 7: undefined
  
  Numbers 0 and 1 access the entry given by index bits [7:0]. An index at or above `ENTRIES` reads 0, and writes to it are dropped.
- R3: A tag-word write also stores PID bits [7:0] as that entry's owner tag.
- R4: A permitted tag-word read loads PID with the entry's owner tag, zero-extended.
- R5: Index bit 31 is a read-only miss flag. A software write changes only bits [30:0].
- R6: A permitted search write keeps `busy` and `lk_req` high for exactly the next cycle, with `lk_vaddr` equal to the written value with bits [9:0] cleared and `lk_user` equal to `user_mode`. A hit then sets the index to the zero-extended `lk_idx`, which also clears the miss flag. A miss sets bit 31 and keeps bits [30:0].
- R7: Reads of the search register and of numbers 6 and 7 return 0.
- R8: With MMU level below 2 or access level 0, every read returns 0 and every write is ignored.
- R9: Reads of numbers 0 to 3 need access-level bit 0. Writes to PID, zone and search need an access level above 1. The index register is always accessible.
- R10: The extended flag is honoured only for the data word, where it reaches bits [63:32]. With any other register number, an extended read returns 0 and an extended write is ignored.
- R11: An accepted read gives `rsp_valid` high with `rsp_rdata` exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ext | input | 1 | Extended (upper word) access |
| req_reg | input | 3 | Register number |
| req_wdata | input | 32 | Write data |
| user_mode | input | 1 | Current privilege mode, 1 = user |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| busy | output | 1 | Search in progress, requests not taken |
| lk_req | output | 1 | Lookup request to the engine |
| lk_vaddr | output | 32 | Page-aligned lookup address |
| lk_user | output | 1 | Mode for the lookup |
| lk_hit | input | 1 | Lookup hit, sampled while `lk_req` is high |
| lk_idx | input | 8 | Matching slot on a hit |

## Verification
Read data and `rsp_valid` are due one edge after the request. The bench therefore drives at a falling edge and samples at the following falling edge. Register and table writes take effect at the request edge, so a readback issued afterwards sees them. After a search write, `busy` and the lookup outputs are sampled at the first falling edge, and the index result is read once `busy` has dropped at the second. A sweep writes and reads back every slot plus several out-of-range indices in three configurations (full, read-only, disabled). Each expected word is computed from its slot number.

// File: rtl/mmu_acc_pkg.sv
package mmu_acc_pkg;

    localparam logic [2:0] REG_DATA   = 3'd0;
    localparam logic [2:0] REG_TAG    = 3'd1;
    localparam logic [2:0] REG_PID    = 3'd2;
    localparam logic [2:0] REG_ZONE   = 3'd3;
    localparam logic [2:0] REG_INDEX  = 3'd4;
    localparam logic [2:0] REG_SEARCH = 3'd5;

    localparam int PAGE_LSB = 10;

    typedef enum logic {
        ST_IDLE,
        ST_SEARCH
    } port_state_e;

endpackage

// File: rtl/mmu_acc_gate.sv
module mmu_acc_gate
    import mmu_acc_pkg::*;
#(
    parameter int MMU_LEVEL    = 3,
    parameter int ACCESS_LEVEL = 3
) (
    input  logic [2:0] reg_sel,
    input  logic       ext,
    output logic       rd_ok,
    output logic       wr_ok
);

    localparam bit ENABLED  = (MMU_LEVEL >= 2) && (ACCESS_LEVEL != 0);
    localparam bit RD_LEVEL = (ACCESS_LEVEL % 2) == 1;
    localparam bit WR_LEVEL = ACCESS_LEVEL > 1;

    logic rd_raw, wr_raw, ext_ok;

    always_comb begin
        rd_raw = 1'b0;
        wr_raw = 1'b0;
        case (reg_sel)
            REG_DATA, REG_TAG: begin
                rd_raw = RD_LEVEL;
                wr_raw = 1'b1;
            end
            REG_PID, REG_ZONE: begin
                rd_raw = RD_LEVEL;
                wr_raw = WR_LEVEL;
            end
            REG_INDEX: begin
                rd_raw = 1'b1;
                wr_raw = 1'b1;
            end
            REG_SEARCH: begin
                rd_raw = 1'b0;
                wr_raw = WR_LEVEL;
            end
            default: begin
                rd_raw = 1'b0;
                wr_raw = 1'b0;
            end
        endcase
    end

    assign ext_ok = !ext || (reg_sel == REG_DATA);
    assign rd_ok  = ENABLED && ext_ok && rd_raw;
    assign wr_ok  = ENABLED && ext_ok && wr_raw;

endmodule

// File: rtl/mmu_acc_store.sv
module mmu_acc_store #(
    parameter int ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  idx,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic        wr_tag,
    input  logic [31:0] wdata,
    input  logic [7:0]  tid_in,
    output logic        in_range,
    output logic [31:0] tag_o,
    output logic [31:0] lo_o,
    output logic [31:0] hi_o,
    output logic [7:0]  tid_o
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [31:0] tag_q [ENTRIES];
    logic [31:0] lo_q  [ENTRIES];
    logic [31:0] hi_q  [ENTRIES];
    logic [7:0]  tid_q [ENTRIES];

    logic [IDX_W-1:0] sel;

    assign in_range = {1'b0, idx} < 9'(ENTRIES);
    assign sel      = idx[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e] <= '0;
                lo_q[e]  <= '0;
                hi_q[e]  <= '0;
                tid_q[e] <= '0;
            end
        end else if (in_range) begin
            if (wr_tag) begin
                tag_q[sel] <= wdata;
                tid_q[sel] <= tid_in;
            end
            if (wr_lo) lo_q[sel] <= wdata;
            if (wr_hi) hi_q[sel] <= wdata;
        end
    end

    assign tag_o = in_range ? tag_q[sel] : '0;
    assign lo_o  = in_range ? lo_q[sel]  : '0;
    assign hi_o  = in_range ? hi_q[sel]  : '0;
    assign tid_o = in_range ? tid_q[sel] : '0;

endmodule

// File: rtl/mmu_tlb_port.sv
module mmu_tlb_port
    import mmu_acc_pkg::*;
#(
    parameter int ENTRIES      = 16,
    parameter int MMU_LEVEL    = 3,
    parameter int ACCESS_LEVEL = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_ext,
    input  logic [2:0]  req_reg,
    input  logic [31:0] req_wdata,
    input  logic        user_mode,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        busy,
    output logic        lk_req,
    output logic [31:0] lk_vaddr,
    output logic        lk_user,
    input  logic        lk_hit,
    input  logic [7:0]  lk_idx
);

    localparam int VPN_W = 32 - PAGE_LSB;

    port_state_e state_q, state_d;

    logic [31:0]      pid_q, zone_q, tlbx_q;
    logic [VPN_W-1:0] vpn_q;
    logic             user_q;

    logic        rd_ok, wr_ok, accept, do_wr, do_rd, launch;
    logic        in_range;
    logic [31:0] tag_w, lo_w, hi_w, rd_val;
    logic [7:0]  tid_w;

    mmu_acc_gate #(
        .MMU_LEVEL   (MMU_LEVEL),
        .ACCESS_LEVEL(ACCESS_LEVEL)
    ) u_gate (
        .reg_sel(req_reg),
        .ext    (req_ext),
        .rd_ok  (rd_ok),
        .wr_ok  (wr_ok)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign do_wr  = accept && req_write && wr_ok;
    assign do_rd  = accept && !req_write;
    assign launch = do_wr && (req_reg == REG_SEARCH);

    mmu_acc_store #(
        .ENTRIES(ENTRIES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (tlbx_q[7:0]),
        .wr_lo   (do_wr && (req_reg == REG_DATA) && !req_ext),
        .wr_hi   (do_wr && (req_reg == REG_DATA) && req_ext),
        .wr_tag  (do_wr && (req_reg == REG_TAG)),
        .wdata   (req_wdata),
        .tid_in  (pid_q[7:0]),
        .in_range(in_range),
        .tag_o   (tag_w),
        .lo_o    (lo_w),
        .hi_o    (hi_w),
        .tid_o   (tid_w)
    );

    always_comb begin
        rd_val = '0;
        if (rd_ok) begin
            case (req_reg)
                REG_DATA:  rd_val = req_ext ? hi_w : lo_w;
                REG_TAG:   rd_val = tag_w;
                REG_PID:   rd_val = pid_q;
                REG_ZONE:  rd_val = zone_q;
                REG_INDEX: rd_val = tlbx_q;
                default:   rd_val = '0;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_SEARCH;
            ST_SEARCH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q     <= '0;
            zone_q    <= '0;
            tlbx_q    <= '0;
            vpn_q     <= '0;
            user_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= do_rd;
            if (do_rd) rsp_rdata <= rd_val;
            unique case (state_q)
                ST_IDLE: begin
                    if (do_wr) begin
                        case (req_reg)
                            REG_PID:    pid_q  <= req_wdata;
                            REG_ZONE:   zone_q <= req_wdata;
                            REG_INDEX:  tlbx_q <= {tlbx_q[31], req_wdata[30:0]};
                            REG_SEARCH: begin
                                vpn_q  <= req_wdata[31:PAGE_LSB];
                                user_q <= user_mode;
                            end
                            default: ;
                        endcase
                    end
                    if (do_rd && rd_ok && (req_reg == REG_TAG) && in_range)
                        pid_q <= {24'd0, tid_w};
                end
                ST_SEARCH: begin
                    if (lk_hit) tlbx_q <= {24'd0, lk_idx};
                    else        tlbx_q <= {1'b1, tlbx_q[30:0]};
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q == ST_SEARCH);
    assign lk_req   = (state_q == ST_SEARCH);
    assign lk_vaddr = {vpn_q, {PAGE_LSB{1'b0}}};
    assign lk_user  = user_q;

endmodule

// File: rtl/mmu_tlb_port_chk.sv
module mmu_tlb_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        lk_hit,
    input logic [7:0]  lk_idx,
    input logic [31:0] tlbx,
    input logic        rsp_valid,
    input logic        req_valid,
    input logic        req_write,
    input logic [2:0]  req_reg
);

    // R6: search state lasts one cycle
    a_r6_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6: hit loads index
    a_r6_hit_index: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lk_hit) |=> (tlbx == {24'd0, $past(lk_idx)}));

    // R6: miss sets flag, keeps low bits
    a_r6_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !lk_hit) |=> (tlbx[31] && (tlbx[30:0] == $past(tlbx[30:0]))));

    // R5: software write never changes bit 31
    a_r5_flag_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !busy && req_reg == 3'd4) |=> (tlbx[31] == $past(tlbx[31])));

    // R11: response follows an accepted read
    a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write && !busy));

endmodule

bind mmu_tlb_port mmu_tlb_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .tlbx     (tlbx_q),
    .rsp_valid(rsp_valid),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_reg  (req_reg)
);

// File: tb/sim_mmu_tlb_port.sv
module sim_mmu_tlb_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_ext = 1'b0;
    logic [2:0]  req_reg = '0;
    logic [31:0] req_wdata = '0;
    logic        user_mode = 1'b0;
    logic        lk_hit = 1'b0;
    logic [7:0]  lk_idx = '0;

    logic        v0, v1, v2, b0, b1, b2, q0, q1, q2, u0u, u1u, u2u;
    logic [31:0] d0, d1, d2, a0, a1, a2;

    int checks = 0;
    int errors = 0;
    logic [31:0] r0, r1, r2;

    always #4 clk = ~clk;

    // full access
    mmu_tlb_port #(.ENTRIES(16), .MMU_LEVEL(3), .ACCESS_LEVEL(3)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ext(req_ext), .req_reg(req_reg), .req_wdata(req_wdata), .user_mode(user_mode),
        .rsp_valid(v0), .rsp_rdata(d0), .busy(b0), .lk_req(q0), .lk_vaddr(a0),
        .lk_user(u0u), .lk_hit(lk_hit), .lk_idx(lk_idx));
    // read-mostly
    mmu_tlb_port #(.ENTRIES(16), .MMU_LEVEL(3), .ACCESS_LEVEL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ext(req_ext), .req_reg(req_reg), .req_wdata(req_wdata), .user_mode(user_mode),
        .rsp_valid(v1), .rsp_rdata(d1), .busy(b1), .lk_req(q1), .lk_vaddr(a1),
        .lk_user(u1u), .lk_hit(lk_hit), .lk_idx(lk_idx));
    // disabled
    mmu_tlb_port #(.ENTRIES(16), .MMU_LEVEL(1), .ACCESS_LEVEL(3)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ext(req_ext), .req_reg(req_reg), .req_wdata(req_wdata), .user_mode(user_mode),
        .rsp_valid(v2), .rsp_rdata(d2), .busy(b2), .lk_req(q2), .lk_vaddr(a2),
        .lk_user(u2u), .lk_hit(lk_hit), .lk_idx(lk_idx));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] rn, input logic ext, input logic [31:0] val);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_ext = ext; req_reg = rn; req_wdata = val;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_ext = 1'b0;
    endtask

    task automatic rd(input logic [2:0] rn, input logic ext);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_ext = ext; req_reg = rn;
        @(negedge clk);
        req_valid = 1'b0; req_ext = 1'b0;
        chk("R11 rsp_valid", {31'd0, v0}, 32'd1);
        r0 = d0; r1 = d1; r2 = d2;
    endtask

    function automatic logic [31:0] tagv(input int i);
        return 32'h1000_0040 + 32'(i) * 32'h0001_0401;
    endfunction
    function automatic logic [31:0] lov(input int i);
        return 32'hA000_0000 ^ (32'(i) * 32'h0101_0013);
    endfunction
    function automatic logic [31:0] hiv(input int i);
        return 32'h5500_0000 + 32'(i) * 32'h0000_0777;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, b0}, 32'd0);
        chk("R1 rsp_valid", {31'd0, v0}, 32'd0);
        rd(3'd4, 1'b0); chk("R1 index", r0, 32'd0);
        rd(3'd2, 1'b0); chk("R1 pid", r0, 32'd0);
        rd(3'd3, 1'b0); chk("R1 zone", r0, 32'd0);
        rd(3'd1, 1'b0); chk("R1 tag", r0, 32'd0);
        rd(3'd0, 1'b0); chk("R1 data", r0, 32'd0);
        @(negedge clk);
        chk("R11 rsp idle", {31'd0, v0}, 32'd0);

        // fill all slots: R2 R3
        for (int i = 0; i < 16; i++) begin
            wr(3'd4, 1'b0, 32'(i));
            wr(3'd2, 1'b0, 32'hA500 + 32'(i) * 3);
            wr(3'd1, 1'b0, tagv(i));
            wr(3'd0, 1'b0, lov(i));
            wr(3'd0, 1'b1, hiv(i));
        end
        // out-of-range slots: R2
        for (int k = 16; k < 20; k++) begin
            wr(3'd4, 1'b0, 32'(k));
            wr(3'd1, 1'b0, 32'hFFFF_FFFF);
            wr(3'd0, 1'b0, 32'hFFFF_FFFF);
            rd(3'd1, 1'b0); chk("R2 oor tag", r0, 32'd0);
            rd(3'd0, 1'b0); chk("R2 oor data", r0, 32'd0);
        end
        wr(3'd2, 1'b0, 32'd0);
        // read back: R2 R4 R10
        for (int i = 0; i < 16; i++) begin
            wr(3'd4, 1'b0, 32'(i));
            rd(3'd1, 1'b0); chk("R2 tag", r0, tagv(i));
            chk("R9 ro tag", r1, tagv(i));
            chk("R8 tag", r2, 32'd0);
            rd(3'd0, 1'b0); chk("R2 data lo", r0, lov(i));
            rd(3'd0, 1'b1); chk("R10 data hi", r0, hiv(i));
            rd(3'd2, 1'b0); chk("R4 pid from owner", r0, (32'(i) * 3) & 32'hFF);
            chk("R9 ro pid unchanged", r1, 32'd0);
        end

        // R5 flag read-only
        wr(3'd4, 1'b0, 32'hFFFF_FFFF);
        rd(3'd4, 1'b0); chk("R5 index write", r0, 32'h7FFF_FFFF);
        chk("R8 index", r2, 32'd0);

        // zone and R9 R10
        wr(3'd3, 1'b0, 32'h1234_5678);
        wr(3'd3, 1'b1, 32'h0);
        rd(3'd3, 1'b0); chk("R10 ext write ignored", r0, 32'h1234_5678);
        chk("R9 ro zone", r1, 32'd0);
        chk("R8 zone", r2, 32'd0);
        rd(3'd3, 1'b1); chk("R10 ext read", r0, 32'd0);

        // R6 hit
        wr(3'd4, 1'b0, 32'd5);
        lk_hit = 1'b1; lk_idx = 8'd9; user_mode = 1'b1;
        wr(3'd5, 1'b0, 32'h1234_5ABC);
        chk("R6 busy", {31'd0, b0}, 32'd1);
        chk("R6 lk_req", {31'd0, q0}, 32'd1);
        chk("R6 vaddr", a0, 32'h1234_5800);
        chk("R6 user", {31'd0, u0u}, 32'd1);
        chk("R9 ro no search", {31'd0, b1}, 32'd0);
        chk("R8 no search", {31'd0, b2}, 32'd0);
        @(negedge clk);
        chk("R6 busy drop", {31'd0, b0}, 32'd0);
        rd(3'd4, 1'b0); chk("R6 hit index", r0, 32'd9);

        // R6 miss
        wr(3'd4, 1'b0, 32'h33);
        lk_hit = 1'b0; user_mode = 1'b0;
        wr(3'd5, 1'b0, 32'h0000_03FF);
        chk("R6 vaddr low", a0, 32'd0);
        chk("R6 user0", {31'd0, u0u}, 32'd0);
        @(negedge clk);
        rd(3'd4, 1'b0); chk("R6 miss index", r0, 32'h8000_0033);
        wr(3'd4, 1'b0, 32'd7);
        rd(3'd4, 1'b0); chk("R5 flag kept", r0, 32'h8000_0007);
        lk_hit = 1'b1; lk_idx = 8'd2;
        wr(3'd5, 1'b0, 32'h0);
        @(negedge clk);
        rd(3'd4, 1'b0); chk("R6 hit clears flag", r0, 32'd2);

        // R7
        rd(3'd5, 1'b0); chk("R7 search read", r0, 32'd0);
        rd(3'd6, 1'b0); chk("R7 reg6", r0, 32'd0);
        rd(3'd7, 1'b0); chk("R7 reg7", r0, 32'd0);

        // R2 slot 0 intact after out-of-range writes
        wr(3'd4, 1'b0, 32'd0);
        rd(3'd1, 1'b0); chk("R2 slot0 intact", r0, tagv(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule